// File: doc/BRIEF.md
# Two-Stage SPI Master Clock Divider

This block turns the system clock into the serial clock of an SPI master. A 13-bit prescaler produces a tick every `pre+1` system cycles. A 6-bit period counter advances on each tick and closes one serial-clock period after `N+1` ticks, so the serial clock runs at sysclk/(pre+1)/(N+1). Two compare values place the edges inside the period. The counter value at which the clock leaves its active level is set by `hi_cmp`. The counter value at which it comes back is set by `lo_cmp`. A bypass input hands the system clock itself to the pin.

A transfer sequencer raises `run` for the length of a transfer. While `run` is low the pin rests at the level chosen by `idle_high`. Together with the clock level, the block gives two one-cycle strobes. `sample_o` marks the leading edge, where the clock leaves its idle level. `launch_o` marks the trailing edge, where it returns. The sequencer can then shift data in lock-step without looking at the clock. Divider settings are taken in at the start of a transfer and after that only when a period closes, so a period is never cut short.

Top module: `spi_sclk_divider`

## Requirements
- R1: Out of reset, and whenever the last sampled `run` is 0, `sclk_o` equals `idle_high` and both strobes are 0.
- R2: With no bypass, `N >= 1`, `lo_cmp = N` and `hi_cmp < N`, one serial period lasts (pre+1)(N+1) system cycles. The clock is at its active level for the first (pre+1)(hi_cmp+1) of them, counted from the first cycle after the edge that samples `run` high.
- R3: `sample_o` is high for exactly the first system cycle of each divided period, that is, the cycle in which the clock has just left its idle level. This includes the first cycle of a transfer.
- R4: `launch_o` is high for exactly the one system cycle in which the divided clock has just returned to its idle level, at offset (pre+1)(hi_cmp+1) into the period.
- R5: With `N = 0`, `pre >= 1` and no bypass, the period is pre+1 cycles. The active level holds for ceil((pre+1)/2) of them. The compare values are ignored.
- R6: With `bypass = 1`, or with pre = 0 and N = 0, the running `sclk_o` follows the system clock (high while it is high). Both strobes are held high on every running cycle, and the divider fields have no effect.
- R7: Values applied to `pre_div`, `n_div`, `hi_cmp`, `lo_cmp` and `bypass` during a transfer change nothing until the edge that closes the current period. That edge loads the values applied in the cycle before it.
- R8: The active level is the inverse of the idle level. With `idle_high = 1` the period opens with a falling edge of `sclk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Transfer in progress |
| idle_high | input | 1 | Idle level of the serial clock (1 = high) |
| bypass | input | 1 | Pass the system clock to the pin |
| pre_div | input | 13 | Prescaler setting, divides by value+1 |
| n_div | input | 6 | Period setting, value+1 ticks per period |
| hi_cmp | input | 6 | Period count after which the clock turns idle |
| lo_cmp | input | 6 | Period count after which the clock turns active |
| sclk_o | output | 1 | Serial clock level |
| sample_o | output | 1 | One-cycle strobe at the leading edge |
| launch_o | output | 1 | One-cycle strobe at the trailing edge |

## Verification
The assertions assume the master-mode setting rules. These are `lo_cmp` equal to `n_div` and `hi_cmp` below `n_div` whenever `n_div` is nonzero. They also assume `idle_high` is held steady while `run` is high. Every directed and random configuration in the bench is built to these rules: `hi_cmp` is drawn below `n_div` and `lo_cmp` is copied from it. The mid-transfer reload test changes settings only within the same rules, so the one-cycle strobe and reload-timing properties stay inside their stated preconditions.

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider #(
  parameter int PRE_W = 13,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             idle_high,
  input  logic             bypass,
  input  logic [PRE_W-1:0] pre_div,
  input  logic [CNT_W-1:0] n_div,
  input  logic [CNT_W-1:0] hi_cmp,
  input  logic [CNT_W-1:0] lo_cmp,
  output logic             sclk_o,
  output logic             sample_o,
  output logic             launch_o
);

  localparam int HALF_W = PRE_W + 1;

  logic             run_q, lvl_q, smp_q, lch_q, byp_q;
  logic [PRE_W-1:0] pre_q, pc_q;
  logic [CNT_W-1:0] n_q, hi_q, lo_q, nc_q;

  logic byp_eff, new_byp, tick, wrap, start, reload;
  logic [HALF_W-1:0] half_m1;

  assign byp_eff = byp_q || (pre_q == '0 && n_q == '0);
  assign new_byp = bypass || (pre_div == '0 && n_div == '0);
  assign tick    = (pc_q == pre_q);
  assign wrap    = run_q && (byp_eff || (tick && nc_q == n_q));
  assign start   = run && !run_q;
  assign reload  = run && (start || wrap);
  assign half_m1 = (({1'b0, pre_q} + HALF_W'(2)) >> 1) - HALF_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      lvl_q <= 1'b0;
      smp_q <= 1'b0;
      lch_q <= 1'b0;
      byp_q <= 1'b0;
      pre_q <= '0;
      n_q   <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      pc_q  <= '0;
      nc_q  <= '0;
    end else begin
      run_q <= run;
      smp_q <= 1'b0;
      lch_q <= 1'b0;
      if (!run) begin
        lvl_q <= 1'b0;
        pc_q  <= '0;
        nc_q  <= '0;
      end else if (reload) begin
        byp_q <= bypass;
        pre_q <= pre_div;
        n_q   <= n_div;
        hi_q  <= hi_cmp;
        lo_q  <= lo_cmp;
        pc_q  <= '0;
        nc_q  <= '0;
        lvl_q <= 1'b1;
        smp_q <= 1'b1;
        lch_q <= new_byp;
      end else begin
        if (tick) begin
          pc_q <= '0;
          nc_q <= nc_q + CNT_W'(1);
        end else begin
          pc_q <= pc_q + PRE_W'(1);
        end
        if (n_q == '0) begin
          if ({1'b0, pc_q} == half_m1) begin
            lvl_q <= 1'b0;
            lch_q <= 1'b1;
          end
        end else if (tick) begin
          if (nc_q == lo_q) begin
            lvl_q <= 1'b1;
            smp_q <= 1'b1;
          end else if (nc_q == hi_q) begin
            lvl_q <= 1'b0;
            lch_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sclk_o   = !run_q ? idle_high : (byp_eff ? clk : (lvl_q ^ idle_high));
  assign sample_o = smp_q;
  assign launch_o = lch_q;

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!sample_o && !launch_o));

  // R3
  first_cycle_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> sample_o);

  // R3
  strobes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !byp_eff) |-> !(sample_o && launch_o));

  // R4
  launch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_o && !byp_eff) |=> (!launch_o || byp_eff));

  // R2
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (pc_q <= pre_q));

  // R2
  period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (nc_q <= n_q));

  // R7
  hold_midperiod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$past(wrap)) |->
      ($stable(pre_q) && $stable(n_q) && $stable(hi_q) && $stable(byp_q)));

  // R6
  bypass_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && byp_eff) |-> (sample_o && launch_o));

endmodule

// File: tb/spi_sclk_divider_tb.sv
module spi_sclk_divider_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, idle_high = 1'b0, bypass = 1'b0;
  logic [12:0] pre_div = '0;
  logic [5:0]  n_div = '0, hi_cmp = '0, lo_cmp = '0;
  logic sclk_o, sample_o, launch_o;

  int total = 0, bad = 0;
  string tag = "R1";

  bit m_run = 0, s_byp = 0;
  int s_pre = 0, s_n = 0, s_hi = 0, ph = 0;

  always #4 clk = ~clk;

  spi_sclk_divider u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .idle_high(idle_high), .bypass(bypass),
    .pre_div(pre_div), .n_div(n_div), .hi_cmp(hi_cmp), .lo_cmp(lo_cmp),
    .sclk_o(sclk_o), .sample_o(sample_o), .launch_o(launch_o)
  );

  function automatic bit m_bypass();
    return s_byp || (s_pre == 0 && s_n == 0);
  endfunction

  function automatic int m_period();
    if (m_bypass()) return 1;
    if (s_n == 0) return s_pre + 1;
    return (s_pre + 1) * (s_n + 1);
  endfunction

  function automatic int m_active();
    if (s_n == 0) return (s_pre + 2) / 2;
    return (s_pre + 1) * (s_hi + 1);
  endfunction

  task automatic chk(input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d exp %0d", tag, what, got, exp);
    end
  endtask

  task automatic load_cfg();
    s_byp = bypass; s_pre = pre_div; s_n = n_div; s_hi = hi_cmp; ph = 0;
  endtask

  task automatic model_edge();
    if (!run) m_run = 0;
    else if (!m_run) begin m_run = 1; load_cfg(); end
    else begin
      ph++;
      if (ph >= m_period()) load_cfg();
    end
  endtask

  task automatic check_now();
    if (!m_run) begin
      chk("sclk", sclk_o, idle_high);
      chk("sample", sample_o, 0);
      chk("launch", launch_o, 0);
    end else if (m_bypass()) begin
      chk("sclk", sclk_o, 0);
      chk("sample", sample_o, 1);
      chk("launch", launch_o, 1);
    end else begin
      chk("sclk", sclk_o, int'(ph < m_active()) ^ int'(idle_high));
      chk("sample", sample_o, int'(ph == 0));
      chk("launch", launch_o, int'(ph == m_active()));
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      model_edge();
      @(negedge clk);
      check_now();
    end
  endtask

  task automatic set_cfg(input bit b, input int p, input int n, input int h);
    bypass = b; pre_div = 13'(p); n_div = 6'(n); hi_cmp = 6'(h); lo_cmp = 6'(n);
  endtask

  task automatic transfer(input int n);
    run = 1'b1; step(n);
    run = 1'b0; step(3);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: got hung exp done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5c1c_0de5));
    @(negedge clk); @(negedge clk);
    tag = "R1"; check_now();
    rst_n = 1'b1;
    step(3);

    tag = "R2"; set_cfg(0, 1, 3, 1); transfer(40);
    tag = "R4"; set_cfg(0, 2, 5, 0); transfer(60);
    tag = "R3"; set_cfg(0, 0, 4, 3); transfer(25);
    tag = "R5"; set_cfg(0, 2, 0, 17); transfer(20);
    tag = "R5"; set_cfg(0, 1, 0, 0);  transfer(12);
    tag = "R5"; set_cfg(0, 6, 0, 3);  transfer(30);
    tag = "R2"; set_cfg(0, 100, 2, 0); transfer(700);

    tag = "R6"; set_cfg(1, 9, 7, 3); run = 1'b1; step(6);
    @(posedge clk); #1;
    chk("sclk high phase", sclk_o, 1);
    @(negedge clk); model_edge(); check_now();
    run = 1'b0; step(3);
    tag = "R6"; set_cfg(0, 0, 0, 5); transfer(8);

    tag = "R8"; idle_high = 1'b1; step(2);
    set_cfg(0, 1, 3, 1); transfer(24);
    idle_high = 1'b0; step(2);

    tag = "R7"; set_cfg(0, 1, 3, 1); run = 1'b1; step(3);
    set_cfg(0, 0, 1, 0); step(20);
    set_cfg(1, 3, 3, 1); step(7);
    set_cfg(0, 2, 2, 1); step(24);
    run = 1'b0; step(3);

    for (int t = 0; t < 40; t++) begin
      int p, n, h;
      p = $urandom_range(0, 7);
      n = $urandom_range(0, 9);
      h = (n == 0) ? 0 : $urandom_range(0, n - 1);
      idle_high = 1'($urandom_range(0, 1));
      tag = (n == 0) ? "R5" : "R2";
      set_cfg($urandom_range(0, 9) == 0, p, n, h);
      run = 1'b1; step($urandom_range(5, 60));
      if ($urandom_range(0, 2) == 0) begin
        tag = "R7";
        p = $urandom_range(0, 7);
        n = $urandom_range(1, 9);
        set_cfg(0, p, n, $urandom_range(0, n - 1));
        step($urandom_range(10, 80));
      end
      run = 1'b0;
      tag = "R1"; step(2);
      idle_high = 1'b0; step(1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule